// File: doc/BRIEF.md
# Masked Video-Memory Word Update Engine

This block changes selected bits of one 16-bit word in video memory and leaves the other bits as they were. A host gives a command with a table base address, an entry number, a word offset inside the entry, a keep-mask and a set-value. The engine works out the word address, loads its write pointer and then its read pointer with that address, reads the word, forms `(old & keep_mask) | set_val`, writes the result back to the same address and signals completion.

A common use is editing the attribute word of a sprite table entry. Each entry is four 16-bit words, and its last word holds the size, priority and palette fields. For example, the attribute value 0x1180 gives a 32x32 sprite with priority 1 and palette 0. Clearing bit 8 of that word (keep-mask 0xFEFF, set-value 0x0000) turns it into 0x1080, which is 16x32. The memory port is single-ported and synchronous, with one cycle of read latency. A `stall` input lets a display-fetch arbiter take the port: while `stall` is high the sequencer stays in its current state.

Top module: `vram_mask_rmw`

## Requirements
- R1: After reset, `busy`, `done` and `mem_en` are 0.
- R2: The target address is `(table_base + entry_idx*4 + word_off) mod 2^ADDR_W`. The read and the write of a command both use this address.
- R3: The value written is `(old & keep_mask) | set_val`, where `old` is the word read. No other memory word changes.
- R4: With `stall` held low, `done` goes high exactly 6 cycles after the clock edge that accepts `start`. It stays high for one cycle.
- R5: `busy` is high from the cycle after acceptance up to and including the `done` cycle. It is low in the cycle after that.
- R6: A `start` that arrives while `busy` is high is ignored. The running command finishes unchanged and no second command follows.
- R7: `mem_en` is never high in a cycle where `stall` is high. Each stalled cycle during a command delays `done` by exactly one cycle, and a `start` given together with `stall` is not accepted.
- R8: Each command makes exactly one memory read (`mem_en`=1, `mem_we`=0) followed by exactly one memory write (`mem_en`=1, `mem_we`=1).
- R9: A sprite attribute edit works: keep 0x0000 with set 0x1180 yields 0x1180, and keep 0xFEFF with set 0x0000 then yields 0x1080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command request, accepted only when idle and not stalled |
| entry_idx | input | IDX_W | Table entry number |
| word_off | input | OFF_W | Word offset inside the entry |
| keep_mask | input | DATA_W | Bits that are 1 keep their old value |
| set_val | input | DATA_W | Bits ORed into the kept value |
| table_base | input | ADDR_W | Base word address of the table |
| stall | input | 1 | Freezes the sequencer and blocks memory access |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Merged write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the read |

## Verification
A stall and a memory access can both be due in the same cycle. When that happens, the stall must win and push the access to a later cycle. The bench raises `stall` at random on cycles where the engine is about to issue its read or its write. A monitor samples the memory port between edges and counts every cycle that has `mem_en` and `stall` high together. The bench then checks that the word written back still equals the merge of the value that was in memory, and that the delay to `done` grows by exactly the number of stalled cycles. Two further collisions are provoked: `start` given together with `stall` while idle, and `start` given while a command is running. Each is judged by checking that no extra access and no extra `busy` period appear.

// File: rtl/rmw_pkg.sv
// Package: shared state encoding for the masked video-memory update engine.
// Assumes the sequencer walks the states in declaration order.
package rmw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETADDR = 3'd1,
        ST_READ    = 3'd2,
        ST_WAIT    = 3'd3,
        ST_MERGE   = 3'd4,
        ST_WRITE   = 3'd5,
        ST_DONE    = 3'd6
    } rmw_state_t;
endpackage

// File: rtl/rmw_addr_gen.sv
// Module: rmw_addr_gen
// Forms the target word address from the base, the entry number and the word
// offset. Each entry holds 2**OFF_W words. The sum wraps modulo 2**ADDR_W.
// Assumes IDX_W + OFF_W <= ADDR_W.
module rmw_addr_gen #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] entry_ofs;

    // Scale the entry number by the entry size and add base and offset.
    always_comb begin
        entry_ofs = ADDR_W'(idx) << OFF_W;
        addr      = base + entry_ofs + ADDR_W'(off);
    end
endmodule

// File: rtl/rmw_seq.sv
// Module: rmw_seq
// Step sequencer: idle, set pointers, read, wait for data, merge, write, done.
// While stall is high, the state holds and no strobe fires. A start is
// accepted only in idle and only when not stalled.
module rmw_seq
    import rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stall,
    output rmw_state_t state,
    output logic       accept,
    output logic       ld_rd_ptr,
    output logic       cap_rdata,
    output logic       do_merge
);
    rmw_state_t nxt;

    // Next-state selection; every non-idle state advances by one step.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_SETADDR;
            ST_SETADDR: nxt = ST_READ;
            ST_READ:    nxt = ST_WAIT;
            ST_WAIT:    nxt = ST_MERGE;
            ST_MERGE:   nxt = ST_WRITE;
            ST_WRITE:   nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Strobes for the datapath; all of them are gated by stall.
    always_comb begin
        accept    = (state == ST_IDLE)    && start && !stall;
        ld_rd_ptr = (state == ST_SETADDR) && !stall;
        cap_rdata = (state == ST_WAIT)    && !stall;
        do_merge  = (state == ST_MERGE)   && !stall;
    end

    // State register; it holds while stall is high.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (!stall) state <= nxt;
    end
endmodule

// File: rtl/rmw_ptrs.sv
// Module: rmw_ptrs
// Holds the separate write and read address pointers. The write pointer is
// loaded with the target address when a command is accepted. The read
// pointer is loaded from the write pointer one step later, so both end up
// pointing at the same word.
module rmw_ptrs #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_wr,
    input  logic              ld_rd,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr
);
    // Write pointer: captured at command acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (ld_wr) wr_ptr <= target;
    end

    // Read pointer: copied from the write pointer in the set-address step.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_ptr <= '0;
        else if (ld_rd) rd_ptr <= wr_ptr;
    end
endmodule

// File: rtl/rmw_merge.sv
// Module: rmw_merge
// Latches the command's mask and value, captures the word that was read, and
// forms (old & keep) | set. Assumes read data is valid in the cycle after
// the read was issued, and that it is held while the sequencer is stalled.
module rmw_merge #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_cmd,
    input  logic              cap_rdata,
    input  logic              do_merge,
    input  logic [DATA_W-1:0] keep_in,
    input  logic [DATA_W-1:0] set_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] keep_q;
    logic [DATA_W-1:0] set_q;
    logic [DATA_W-1:0] old_q;

    // Command operands: held for the whole command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
            set_q  <= '0;
        end else if (ld_cmd) begin
            keep_q <= keep_in;
            set_q  <= set_in;
        end
    end

    // Old word: captured when the read data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)         old_q <= '0;
        else if (cap_rdata) old_q <= rdata;
    end

    // Merge register: AND with the keep-mask, then OR with the set-value.
    always_ff @(posedge clk) begin
        if (!rst_n)        merged <= '0;
        else if (do_merge) merged <= (old_q & keep_q) | set_q;
    end
endmodule

// File: rtl/vram_mask_rmw.sv
// Module: vram_mask_rmw (top)
// Masked read-modify-write of one word in a single-port synchronous video
// memory with one cycle of read latency. The stall input comes from an
// external arbiter: it freezes the sequencer and blocks the memory port.
module vram_mask_rmw
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  entry_idx,
    input  logic [OFF_W-1:0]  word_off,
    input  logic [DATA_W-1:0] keep_mask,
    input  logic [DATA_W-1:0] set_val,
    input  logic [ADDR_W-1:0] table_base,
    input  logic              stall,
    output logic              busy,
    output logic              done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    rmw_state_t        state;
    logic              accept;
    logic              ld_rd_ptr;
    logic              cap_rdata;
    logic              do_merge;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [DATA_W-1:0] merged;

    rmw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) addr_i (
        .base (table_base),
        .idx  (entry_idx),
        .off  (word_off),
        .addr (target)
    );

    rmw_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stall     (stall),
        .state     (state),
        .accept    (accept),
        .ld_rd_ptr (ld_rd_ptr),
        .cap_rdata (cap_rdata),
        .do_merge  (do_merge)
    );

    rmw_ptrs #(.ADDR_W(ADDR_W)) ptrs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_wr  (accept),
        .ld_rd  (ld_rd_ptr),
        .target (target),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr)
    );

    rmw_merge #(.DATA_W(DATA_W)) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_cmd    (accept),
        .cap_rdata (cap_rdata),
        .do_merge  (do_merge),
        .keep_in   (keep_mask),
        .set_in    (set_val),
        .rdata     (mem_rdata),
        .merged    (merged)
    );

    // Status and memory port decode from the sequencer state.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        mem_en    = ((state == ST_READ) || (state == ST_WRITE)) && !stall;
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? wr_ptr : rd_ptr;
        mem_wdata = merged;
    end
endmodule

// File: rtl/vram_mask_rmw_chk.sv
// Module: vram_mask_rmw_chk
// Protocol checker for vram_mask_rmw, attached by bind. It watches only the
// ports and keeps two small pieces of history: the last read address and
// whether a read has happened since the last write.
module vram_mask_rmw_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              stall,
    input logic              busy,
    input logic              done,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    logic [ADDR_W-1:0] last_rd;
    logic              rd_pending;

    // History of the port: the last read address and an open read awaiting its write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd    <= '0;
            rd_pending <= 1'b0;
        end else if (mem_en && !mem_we) begin
            last_rd    <= mem_addr;
            rd_pending <= 1'b1;
        end else if (mem_en && mem_we) begin
            rd_pending <= 1'b0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);
    p_same_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_addr == last_rd));
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !stall) |=> !done);
    p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
    p_done_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_start_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && !$past(stall)));
    p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !mem_en);
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall) |=> busy);
    p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> rd_pending);
    p_one_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> !rd_pending);
endmodule

bind vram_mask_rmw vram_mask_rmw_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stall    (stall),
    .busy     (busy),
    .done     (done),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/vram_mask_rmw_tb_top.sv
// Bench for vram_mask_rmw: owns the video memory model, drives commands with
// random and directed operands and random stalls, and checks results against
// values it computes itself.
module vram_mask_rmw_tb_top;
    localparam int AW = 10;
    localparam int IW = 6;
    localparam int OW = 2;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] entry_idx = '0;
    logic [OW-1:0] word_off = '0;
    logic [DW-1:0] keep_mask = '0;
    logic [DW-1:0] set_val = '0;
    logic [AW-1:0] table_base = '0;
    logic          stall = 1'b0;
    logic          busy, done, mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    logic [DW-1:0] ram [DEPTH];
    logic [DW-1:0] shadow [DEPTH];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int n_rd = 0, n_wr = 0, n_viol = 0;
    logic [AW-1:0] rd_at, wr_at;

    always #5 clk = ~clk;

    vram_mask_rmw #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_idx(entry_idx),
        .word_off(word_off), .keep_mask(keep_mask), .set_val(set_val),
        .table_base(table_base), .stall(stall), .busy(busy), .done(done),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: single port, synchronous, read data held between reads.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    // Port monitor: samples mid-way between the negedge drive and the next posedge.
    always @(negedge clk) begin
        #2;
        if (mem_en && stall) n_viol++;
        if (mem_en && !mem_we) begin n_rd++; rd_at = mem_addr; end
        if (mem_en && mem_we)  begin n_wr++; wr_at = mem_addr; end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] calc_addr(input logic [AW-1:0] b,
                                                input logic [IW-1:0] i,
                                                input logic [OW-1:0] o);
        int s;
        s = (int'(b) + int'(i) * (1 << OW) + int'(o)) % DEPTH;
        return AW'(s);
    endfunction

    function automatic logic [DW-1:0] calc_merge(input logic [DW-1:0] old,
                                                 input logic [DW-1:0] k,
                                                 input logic [DW-1:0] v);
        return (old & k) | v;
    endfunction

    // One command; stall_pct sets random stall density, poke sends a start while busy.
    task automatic run_cmd(input logic [IW-1:0] i, input logic [OW-1:0] o,
                           input logic [DW-1:0] k, input logic [DW-1:0] v,
                           input logic [AW-1:0] b, input int stall_pct,
                           input bit poke);
        logic [AW-1:0] ea;
        logic [DW-1:0] ev;
        int lat, nst;
        bit busy_ok;
        ea = calc_addr(b, i, o);
        ev = calc_merge(shadow[ea], k, v);
        @(negedge clk);
        n_rd = 0; n_wr = 0; n_viol = 0;
        entry_idx = i; word_off = o; keep_mask = k; set_val = v;
        table_base = b; start = 1'b1; stall = 1'b0;
        @(negedge clk);
        start = 1'b0;
        lat = 1; nst = 0; busy_ok = 1'b1;
        while (!done && lat < 200) begin
            if (!busy) busy_ok = 1'b0;
            stall = (($urandom % 100) < stall_pct);
            if (stall) nst++;
            if (poke && lat == 2) begin
                start = 1'b1;
                entry_idx = i ^ 1;
                set_val = ~v;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        stall = 1'b0; start = 1'b0;
        check(busy_ok, "R5", "busy high while running", 0, 1);
        check(lat == 6 + nst, nst == 0 ? "R4" : "R7", "cycles to done", lat, 6 + nst);
        @(negedge clk);
        check(!done && !busy, "R5", "done/busy after completion", {done, busy}, 0);
        shadow[ea] = ev;
        check(ram[ea] == ev, "R3", "merged word", ram[ea], ev);
        check(n_rd == 1 && n_wr == 1, "R8", "reads*16+writes", n_rd * 16 + n_wr, 17);
        check(rd_at == ea && wr_at == ea, "R2", "read/write address", {rd_at, wr_at}, {ea, ea});
        check(n_viol == 0, "R7", "access during stall", n_viol, 0);
        if (poke) check(n_wr == 1 && ram[calc_addr(b, i ^ 1, o)] == shadow[calc_addr(b, i ^ 1, o)],
                        "R6", "start while busy ignored", n_wr, 1);
    endtask

    task automatic full_compare(input string req);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++) if (ram[a] !== shadow[a]) bad++;
        check(bad == 0, req, "untouched words mismatch count", bad, 0);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(0, "WDOG", "watchdog expired", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        for (int a = 0; a < DEPTH; a++) begin
            ram[a] = DW'(a * 40503) ^ 16'h5A5A;
            shadow[a] = ram[a];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy, "R1", "busy in reset", busy, 0);
        check(!done, "R1", "done in reset", done, 0);
        check(!mem_en, "R1", "mem_en in reset", mem_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_en, "R1", "idle after reset", {busy, mem_en}, 0);

        // R9: sprite attribute edit on the last word of an entry
        run_cmd(6'd5, 2'd3, 16'h0000, 16'h1180, 10'h040, 0, 0);
        check(ram[calc_addr(10'h040, 6'd5, 2'd3)] == 16'h1180, "R9", "32x32 attr",
              ram[calc_addr(10'h040, 6'd5, 2'd3)], 16'h1180);
        run_cmd(6'd5, 2'd3, 16'hFEFF, 16'h0000, 10'h040, 0, 0);
        check(ram[calc_addr(10'h040, 6'd5, 2'd3)] == 16'h1080, "R9", "16x32 attr",
              ram[calc_addr(10'h040, 6'd5, 2'd3)], 16'h1080);

        // R2: address wrap at the top of memory, and the all-keep / all-set extremes
        run_cmd(6'd63, 2'd3, 16'hFFFF, 16'h0000, 10'h3F0, 0, 0);
        run_cmd(6'd0, 2'd0, 16'h0000, 16'hFFFF, 10'h3FF, 0, 0);
        run_cmd(6'd1, 2'd2, 16'h00FF, 16'hA500, 10'h000, 0, 0);

        // R6: start pulsed during a running command
        run_cmd(6'd10, 2'd1, 16'hF0F0, 16'h0303, 10'h100, 0, 1);

        // R7: start together with stall while idle must not be accepted
        @(negedge clk);
        n_rd = 0; n_wr = 0;
        start = 1'b1; stall = 1'b1;
        @(negedge clk);
        start = 1'b0; stall = 1'b0;
        check(!busy, "R7", "start under stall accepted", busy, 0);
        @(negedge clk);
        check(!busy && n_rd == 0 && n_wr == 0, "R7", "access after stalled start",
              n_rd + n_wr, 0);

        // R7: heavy stalls on every step, including the read and write steps
        run_cmd(6'd20, 2'd2, 16'h0F0F, 16'h8001, 10'h200, 70, 0);

        // Random commands with mixed stall density
        for (int n = 0; n < 40; n++) begin
            run_cmd(IW'($urandom), OW'($urandom), DW'($urandom), DW'($urandom),
                    AW'($urandom), (n % 3) * 25, (n % 7) == 3);
        end
        full_compare("R3");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule